// File: doc/BRIEF.md
# Grouped Change-of-State Input Interrupt Controller

This block watches 48 digital input pins and presents them to software through a byte-wide register window of eight locations. Each pin passes through a two-stage synchronizer. Software can read the synchronized levels as six bytes. Every pin is also watched for transitions. The pins are split into six groups of eight, and a transition in either direction on any pin of an enabled group latches a flag for that group. While any group flag is latched, a level-high interrupt request is raised.

Software picks which groups may raise the interrupt by writing an enable mask. The interrupt line may be shared with other devices. For that reason the status byte carries a pending indicator that is low when this block is the source, next to the six group flags. Reading the status byte returns the flags and clears them. A transition seen in the same clock as that read is not lost: its flag is latched again right away.

Top module: `cosirq_ctrl`

## Requirements
- R1: Data reads are combinational from the synchronized pins. Offsets 0, 1 and 2 return groups 0, 1 and 2. Offsets 4, 5 and 6 return groups 3, 4 and 5. Bit n of group g's byte is pin 8*g+n. A pin change is visible in reads two clock edges after it is applied.
- R2: A read of offset 3 returns 0x00, and bit 7 of the status byte at offset 7 always reads 0.
- R3: A write to offset 7 loads data bits 5:0 as the group enable mask (bit k enables group k). Writes to offsets 0 to 6 have no effect on the enable mask or on any read value.
- R4: A rising or a falling transition on any pin of an enabled group sets that group's flag on the third clock edge after the pin changes. Transitions in disabled groups set no flag.
- R5: The status byte at offset 7 holds the group flags in bits 5:0, and bit 6 is 0 exactly when at least one flag is set.
- R6: A read of offset 7 returns the flags as they stood before the read, and clears them on the clock edge where the read strobe is sampled.
- R7: When a group's transition is detected on the same edge as a clearing read, that group's flag is set after the edge.
- R8: The interrupt output is high exactly when at least one group flag is set. It goes low in the cycle after a clearing read if no new transition arrived.
- R9: After reset the enable mask is zero, no flag is set, the interrupt is low and the status reads 0x40. Writing 0 to offset 7 and then reading offset 7 once gives the same quiet state, whatever the pins do afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 3 | Register offset within the window |
| rd_i | input | 1 | Read strobe; with offset 7 it clears the flags |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current offset |
| pins_i | input | 48 | Asynchronous input pins |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the read and write strobes are never both high in one cycle. They also assume that the offset is stable while a strobe is high. The bench drives each bus access for exactly one cycle, changing signals at the falling edge, so both conditions hold. The bench also assumes a single change per observation window, so that it can predict which flags are set. The random stimulus keeps to this: before each new pin pattern it lets the pins settle for at least four cycles and clears the flags.

// File: rtl/cos_pkg.sv
// Shared sizing and register offsets for the change-of-state controller.
// Assumes six groups of eight pins behind a 3-bit offset window.
package cos_pkg;
    localparam int GROUP_W     = 8;
    localparam int NUM_GROUPS  = 6;
    localparam int NUM_PINS    = GROUP_W * NUM_GROUPS;
    localparam int ADDR_W      = 3;
    localparam int HALF_GROUPS = NUM_GROUPS / 2;
    localparam logic [ADDR_W-1:0] GAP_OFS    = ADDR_W'(HALF_GROUPS);
    localparam logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(NUM_GROUPS + 1);
endpackage

// File: rtl/cos_in_sync.sv
// Two-flop synchronizer plus one history stage per pin. Flags a change on
// any line whose synchronized value differs from the value one clock earlier.
// Assumes the pins may be fully asynchronous to clk.
module cos_in_sync #(
    parameter int W = cos_pkg::NUM_PINS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] chg_o
);
    logic [W-1:0] meta_q, sync_q, hist_q;

    // Capture pins into the synchronizer chain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pins_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    // Flag lines whose value moved between the last two samples.
    always_comb begin
        sync_o = sync_q;
        chg_o  = sync_q ^ hist_q;
    end
endmodule

// File: rtl/cos_flag_bank.sv
// Per-group sticky change flags. A group flag sets when any line of an
// enabled group changes; a clear request drops the old flags, but a change
// in the same cycle still sets its flag. Assumes chg_i is one cycle wide.
module cos_flag_bank #(
    parameter int NG = cos_pkg::NUM_GROUPS,
    parameter int GW = cos_pkg::GROUP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NG*GW-1:0] chg_i,
    input  logic [NG-1:0]   en_i,
    input  logic            clr_i,
    output logic [NG-1:0]   flags_o
);
    logic [NG-1:0] grp_chg, set_v, flags_q;

    // Reduce each group's line changes to one bit and gate by its enable.
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_chg[g] = |chg_i[g*GW +: GW];
        assign set_v[g]   = grp_chg[g] & en_i[g];
    end

    // Hold flags, clear on request, and let new changes win over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (clr_i ? '0 : flags_q) | set_v;
    end

    assign flags_o = flags_q;

    a_r4_enabled_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((flags_q & $past(set_v)) == $past(set_v)));
    a_r4_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(grp_chg & en_i)) == '0));
    a_r7_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flags_q == $past(set_v)));
endmodule

// File: rtl/cos_regfile.sv
// Byte register window: six input bytes with a gap at the middle offset,
// and a status/enable location at the last offset. Owns the enable mask and
// issues the flag clear on a status read. Assumes rd_i and wr_i are exclusive.
module cos_regfile
    import cos_pkg::*;
#(
    parameter int NG = NUM_GROUPS,
    parameter int GW = GROUP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [7:0]       wdata_i,
    input  logic [NG*GW-1:0] sync_i,
    input  logic [NG-1:0]    flags_i,
    output logic [NG-1:0]    en_o,
    output logic             clr_o,
    output logic [7:0]       rdata_o
);
    localparam int PAD_W = 8 - NG - 1;

    logic [NG-1:0] en_q;
    logic          wr_en;
    logic          unused_wbits;

    assign wr_en        = wr_i && (addr_i == STATUS_OFS);
    assign clr_o        = rd_i && (addr_i == STATUS_OFS);
    assign unused_wbits = ^wdata_i[7:NG];

    // Load the group enable mask on a write to the status offset.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata_i[NG-1:0];
    end

    // Select the byte addressed: a group, the gap, or the status byte.
    always_comb begin
        rdata_o = '0;
        if (addr_i == STATUS_OFS) begin
            rdata_o = {{PAD_W{1'b0}}, ~(|flags_i), flags_i};
        end else begin
            for (int g = 0; g < NG; g++) begin
                if (addr_i == ADDR_W'(g + ((g >= HALF_GROUPS) ? 1 : 0)))
                    rdata_o = sync_i[g*GW +: GW];
            end
        end
    end

    assign en_o = en_q;

    a_r3_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == STATUS_OFS) |=> (en_o == $past(wdata_i[NG-1:0])));
    a_r3_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == STATUS_OFS) |=> $stable(en_o));
    a_r2_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == GAP_OFS) |-> (rdata_o == 8'h00));
endmodule

// File: rtl/cosirq_ctrl.sv
// Top of the change-of-state interrupt controller: synchronizes 48 pins,
// latches per-group change flags for enabled groups and raises irq_o while
// any flag is held. Assumes one bus access per strobe cycle.
module cosirq_ctrl
    import cos_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic [7:0]           wdata_i,
    output logic [7:0]           rdata_o,
    input  logic [NUM_PINS-1:0]  pins_i,
    output logic                 irq_o
);
    logic [NUM_PINS-1:0]   sync_v, chg_v;
    logic [NUM_GROUPS-1:0] en_v, flags_v;
    logic                  clr_v;

    cos_in_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .sync_o (sync_v),
        .chg_o  (chg_v)
    );

    cos_flag_bank #(.NG(NUM_GROUPS), .GW(GROUP_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .chg_i   (chg_v),
        .en_i    (en_v),
        .clr_i   (clr_v),
        .flags_o (flags_v)
    );

    cos_regfile #(.NG(NUM_GROUPS), .GW(GROUP_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr_i),
        .rd_i    (rd_i),
        .wr_i    (wr_i),
        .wdata_i (wdata_i),
        .sync_i  (sync_v),
        .flags_i (flags_v),
        .en_o    (en_v),
        .clr_o   (clr_v),
        .rdata_o (rdata_o)
    );

    // Raise the request while any group flag is held.
    assign irq_o = |flags_v;

    a_r5_pending_low: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == STATUS_OFS) |-> (rdata_o[6] == !irq_o && rdata_o[7] == 1'b0));
    a_r8_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == STATUS_OFS && !(|(chg_v))) |=> !irq_o);
    a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en_v == '0 && !irq_o) |=> !irq_o);
endmodule

// File: tb/cosirq_ctrl_bench.sv
module cosirq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] pins = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    cosirq_ctrl u_cosirq_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata), .pins_i(pins), .irq_o(irq)
    );

    always #2 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic logic [7:0] exp_byte(input logic [47:0] p, input int a);
        if (a < 3)       return p[a*8 +: 8];
        else if (a == 3) return 8'h00;
        else if (a < 7)  return p[(a-1)*8 +: 8];
        return 8'h00;
    endfunction

    function automatic logic [5:0] exp_flags(input logic [5:0] en,
                                             input logic [47:0] oldp,
                                             input logic [47:0] newp);
        logic [5:0] f;
        for (int g = 0; g < 6; g++)
            f[g] = en[g] && (oldp[g*8 +: 8] != newp[g*8 +: 8]);
        return f;
    endfunction

    function automatic logic [7:0] exp_status(input logic [5:0] f);
        return {1'b0, (f == 6'd0), f};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] v);
        addr = a;
        wdata = v;
        wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    logic [7:0]  d;
    logic [47:0] oldp;
    logic [5:0]  en;
    logic [5:0]  ef;

    initial begin
        void'($urandom(32'd2718));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R9: reset state
        chk("R9", "irq after reset", 64'(irq), 64'd0);
        bus_rd(3'd7, d);
        chk("R9", "status after reset", 64'(d), 64'h40);

        // R1/R2: data byte mapping under random patterns; gap reads zero
        for (int i = 0; i < 8; i++) begin
            pins = {$urandom, $urandom};
            idle(2);
            for (int a = 0; a < 7; a++) begin
                bus_rd(3'(a), d);
                chk((a == 3) ? "R2" : "R1", "data byte", 64'(d), 64'(exp_byte(pins, a)));
            end
        end
        bus_rd(3'd7, d);
        chk("R4", "disabled groups raise nothing", 64'(d), 64'h40);

        // R3: writes to data offsets are ignored
        for (int a = 0; a < 7; a++) bus_wr(3'(a), 8'h3F);
        pins = ~pins;
        idle(4);
        bus_rd(3'd1, d);
        chk("R3", "data after ignored writes", 64'(d), 64'(exp_byte(pins, 1)));
        chk("R3", "irq after ignored writes", 64'(irq), 64'd0);
        bus_rd(3'd7, d);
        chk("R3", "status after ignored writes", 64'(d), 64'h40);

        // R4/R5/R6/R8: rising edge in enabled group 2
        bus_wr(3'd7, 8'h04);
        pins[17] = ~pins[17];
        idle(2);
        chk("R4", "flag not before third edge", 64'(irq), 64'd0);
        idle(1);
        chk("R8", "irq with flag set", 64'(irq), 64'd1);
        bus_rd(3'd7, d);
        chk("R5", "status group 2", 64'(d), 64'h04);
        chk("R6", "irq drops after clearing read", 64'(irq), 64'd0);
        bus_rd(3'd7, d);
        chk("R6", "status after clear", 64'(d), 64'h40);
        pins[17] = ~pins[17];
        idle(4);
        bus_rd(3'd7, d);
        chk("R4", "opposite edge sets flag", 64'(d), 64'h04);
        pins[5] = ~pins[5];
        idle(4);
        bus_rd(3'd7, d);
        chk("R4", "disabled group 0 ignored", 64'(d), 64'h40);

        // R7: change detected on the clearing edge is kept
        bus_wr(3'd7, 8'h01);
        pins[0] = ~pins[0];
        idle(3);
        chk("R8", "irq before concurrent case", 64'(irq), 64'd1);
        pins[3] = ~pins[3];
        idle(2);
        bus_rd(3'd7, d);
        chk("R7", "read returns old flags", 64'(d), 64'h01);
        chk("R7", "irq kept by concurrent change", 64'(irq), 64'd1);
        bus_rd(3'd7, d);
        chk("R7", "flag re-latched", 64'(d), 64'h01);
        bus_rd(3'd7, d);
        chk("R6", "quiet after second clear", 64'(d), 64'h40);

        // R4/R5: two groups at once
        bus_wr(3'd7, 8'h3F);
        pins[9]  = ~pins[9];
        pins[47] = ~pins[47];
        idle(4);
        bus_rd(3'd7, d);
        chk("R5", "groups 1 and 5", 64'(d), 64'h22);

        // R4/R8: random enables and sparse pin changes
        for (int i = 0; i < 40; i++) begin
            en = 6'($urandom);
            bus_wr(3'd7, {2'($urandom), en});
            idle(4);
            bus_rd(3'd7, d);
            oldp = pins;
            pins = pins ^ ({$urandom, $urandom} & {$urandom, $urandom}
                           & {$urandom, $urandom});
            ef = exp_flags(en, oldp, pins);
            idle(4);
            chk("R8", "irq random", 64'(irq), 64'(ef != 6'd0));
            bus_rd(3'd7, d);
            chk("R4", "status random", 64'(d), 64'(exp_status(ef)));
        end

        // R9: disable all then read once gives quiet state
        pins = ~pins;
        idle(1);
        bus_wr(3'd7, 8'h00);
        bus_rd(3'd7, d);
        pins = ~pins;
        idle(4);
        chk("R9", "irq after disable", 64'(irq), 64'd0);
        bus_rd(3'd7, d);
        chk("R9", "status after disable", 64'(d), 64'h40);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule